// File: doc/BRIEF.md
# Multi-Register Structure Interleave Unit

This unit sits between a vector load/store address path and the vector register file. It converts between a contiguous little-endian byte stream of up to 64 bytes and a list of up to four vector registers, for loads and stores of multiple structures. Each structure holds n elements, with n from 1 to 4. On the load side, the memory stream is split so that element j of every structure lands in list register j. On the store side, the register contents are interleaved back into one packed stream.

Each operation is presented with `valid_i` for one cycle. The unit decodes the register list, which is either consecutive or stepping by two and wraps modulo 32. It reports the byte count the address generator must advance by. It produces the load result and the store result together, one cycle later. The caller uses whichever result matches its operation. Operand combinations that have no defined form are flagged as illegal and produce nothing.

Top module: `sil_top`

## Requirements
- R1: List position k targets register (t + k) mod 32 when `alt_i`=0 and (t + 2k) mod 32 when `alt_i`=1, reported on `reg_num_o[5k +: 5]`.
- R2: The register count is `regs_m1_i`+1 when `elems_m1_i`=0, and otherwise equals n = `elems_m1_i`+1. `reg_en_o` has exactly the low count bits set.
- R3: With n=1 the load fills the registers contiguously. Byte p of list register k equals memory byte k*W+p, where W is 16 when `wide_i`=1 and 8 when `wide_i`=0.
- R4: With n>1 the element size is 1<<`esize_i` bytes (0=byte, 1=half, 2=word, 3=dword). Memory element i goes to list register i mod n, lane i div n. Elements are little-endian.
- R5: The store output is the exact inverse of R3/R4. Register byte `reg_src_i[128k+8p +: 8]` is placed at the memory byte that the load would have read it from.
- R6: `byte_count_o` equals register count times W.
- R7: `esize_i`=3 with `wide_i`=0 (a single 64-bit lane) is illegal when n>1 and legal when n=1.
- R8: `alt_i`=1 with n=1 is illegal.
- R9: On an illegal operation `illegal_o`=1, `reg_en_o`=0, `byte_count_o`=0, and both data outputs are all zero.
- R10: Register bytes at or above W, bytes of disabled registers, and memory bytes at or above the byte count are zero.
- R11: Results appear in the cycle after `valid_i`. `valid_o` is a one-cycle copy of `valid_i`. Outputs hold their value while `valid_i` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| valid_i | input | 1 | Operation present |
| elems_m1_i | input | 2 | Structure element count minus one |
| regs_m1_i | input | 2 | Register count minus one (used when n=1) |
| esize_i | input | 2 | log2 of element bytes |
| wide_i | input | 1 | 1 = 128-bit registers, 0 = 64-bit |
| alt_i | input | 1 | 1 = register numbers step by two |
| first_reg_i | input | 5 | First register number t |
| mem_i | input | 512 | Memory bytes for a load, byte b at [8b +: 8] |
| reg_src_i | input | 512 | Register data for a store, list register k at [128k +: 128] |
| valid_o | output | 1 | Result present |
| illegal_o | output | 1 | Operand combination undefined |
| byte_count_o | output | 7 | Bytes transferred |
| reg_en_o | output | 4 | Enabled list positions |
| reg_num_o | output | 20 | Register number per list position |
| reg_data_o | output | 512 | Load result, list register k at [128k +: 128] |
| mem_o | output | 512 | Store result, byte b at [8b +: 8] |

## Verification
The bench aims at register numbering that wraps past 31, in both step modes. A design that drops the modulo, or steps by one in alternating mode, would report wrong targets. It also exercises three-element structures, where division by a non-power-of-two is needed. A shift-based shortcut there would scatter elements into the wrong lanes. Further cases cover the 64-bit-register forms, where the upper eight bytes must read as zero, and the two illegal combinations, which must emit no enables and no data. The n=1 forms with several registers check that contiguous filling is not confused with de-interleaving.

// File: rtl/sil_pkg.sv
package sil_pkg;
  localparam int unsigned ESIZE_W = 2;
  localparam int unsigned ESIZE_DWORD = 3;

  function automatic int unsigned reg_bytes(input logic wide, input int unsigned full);
    return wide ? full : full / 2;
  endfunction
endpackage

// File: rtl/sil_ctrl.sv
module sil_ctrl
  import sil_pkg::*;
#(
  parameter int unsigned NUM_REGS  = 4,
  parameter int unsigned REG_BYTES = 16,
  parameter int unsigned RIDX_W    = 5,
  localparam int unsigned CNT_W    = $clog2(NUM_REGS * REG_BYTES + 1),
  localparam int unsigned RC_W     = $clog2(NUM_REGS + 1)
) (
  input  logic [1:0]                 elems_m1_i,
  input  logic [1:0]                 regs_m1_i,
  input  logic [ESIZE_W-1:0]         esize_i,
  input  logic                       wide_i,
  input  logic                       alt_i,
  input  logic [RIDX_W-1:0]          first_reg_i,
  output logic                       illegal_o,
  output logic [RC_W-1:0]            reg_cnt_o,
  output logic [CNT_W-1:0]           byte_cnt_o,
  output logic [NUM_REGS-1:0]        reg_en_o,
  output logic [NUM_REGS*RIDX_W-1:0] reg_num_o
);
  logic single;
  logic [RC_W-1:0] cnt;

  assign single = (elems_m1_i == 2'd0);

  always_comb begin
    illegal_o = (single && alt_i) ||
                (!single && !wide_i && esize_i == ESIZE_W'(ESIZE_DWORD));
    cnt       = single ? RC_W'(regs_m1_i) + RC_W'(1) : RC_W'(elems_m1_i) + RC_W'(1);
    reg_cnt_o = illegal_o ? '0 : cnt;
    byte_cnt_o = CNT_W'(int'(reg_cnt_o) * int'(reg_bytes(wide_i, REG_BYTES)));
  end

  for (genvar k = 0; k < NUM_REGS; k++) begin : g_list
    logic [RIDX_W-1:0] step;
    assign step = alt_i ? RIDX_W'(2 * k) : RIDX_W'(k);
    // register index arithmetic wraps naturally at RIDX_W bits
    assign reg_num_o[k*RIDX_W +: RIDX_W] = first_reg_i + step;
    assign reg_en_o[k] = (int'(reg_cnt_o) > k);
  end
endmodule

// File: rtl/sil_load_xbar.sv
module sil_load_xbar
  import sil_pkg::*;
#(
  parameter int unsigned NUM_REGS  = 4,
  parameter int unsigned REG_BYTES = 16,
  localparam int unsigned MEM_BYTES = NUM_REGS * REG_BYTES,
  localparam int unsigned RC_W      = $clog2(NUM_REGS + 1)
) (
  input  logic [MEM_BYTES*8-1:0] mem_i,
  input  logic [1:0]             elems_m1_i,
  input  logic [ESIZE_W-1:0]     esize_i,
  input  logic                   wide_i,
  input  logic [RC_W-1:0]        reg_cnt_i,
  output logic [MEM_BYTES*8-1:0] reg_data_o
);
  for (genvar k = 0; k < NUM_REGS; k++) begin : g_reg
    for (genvar p = 0; p < REG_BYTES; p++) begin : g_byte
      int unsigned lane, sub, elem, src, w;
      logic on;
      always_comb begin
        w    = reg_bytes(wide_i, REG_BYTES);
        lane = p >> esize_i;
        sub  = p & ((1 << esize_i) - 1);
        elem = lane * (int'(elems_m1_i) + 1) + k;
        if (elems_m1_i == 2'd0) src = k * w + p;
        else                    src = (elem << esize_i) + sub;
        on = (int'(reg_cnt_i) > k) && (p < w) && (src < MEM_BYTES);
      end
      assign reg_data_o[(k*REG_BYTES+p)*8 +: 8] = on ? mem_i[(src % MEM_BYTES)*8 +: 8] : 8'h00;
    end
  end
endmodule

// File: rtl/sil_store_xbar.sv
module sil_store_xbar
  import sil_pkg::*;
#(
  parameter int unsigned NUM_REGS  = 4,
  parameter int unsigned REG_BYTES = 16,
  localparam int unsigned MEM_BYTES = NUM_REGS * REG_BYTES,
  localparam int unsigned RC_W      = $clog2(NUM_REGS + 1)
) (
  input  logic [MEM_BYTES*8-1:0] reg_src_i,
  input  logic [1:0]             elems_m1_i,
  input  logic [ESIZE_W-1:0]     esize_i,
  input  logic                   wide_i,
  input  logic [RC_W-1:0]        reg_cnt_i,
  output logic [MEM_BYTES*8-1:0] mem_o
);
  for (genvar b = 0; b < MEM_BYTES; b++) begin : g_byte
    int unsigned elem, sub, n, k, p, w;
    logic on;
    always_comb begin
      w    = reg_bytes(wide_i, REG_BYTES);
      n    = int'(elems_m1_i) + 1;
      elem = b >> esize_i;
      sub  = b & ((1 << esize_i) - 1);
      if (n == 1) begin
        k = b / w;
        p = b % w;
      end else begin
        // n may be 3: true divide, not a shift
        k = elem % n;
        p = ((elem / n) << esize_i) + sub;
      end
      on = (b < int'(reg_cnt_i) * w);
    end
    assign mem_o[b*8 +: 8] =
        on ? reg_src_i[((k % NUM_REGS)*REG_BYTES + (p % REG_BYTES))*8 +: 8] : 8'h00;
  end
endmodule

// File: rtl/sil_top.sv
module sil_top
  import sil_pkg::*;
#(
  parameter int unsigned NUM_REGS  = 4,
  parameter int unsigned REG_BYTES = 16,
  parameter int unsigned RIDX_W    = 5,
  localparam int unsigned MEM_BYTES = NUM_REGS * REG_BYTES,
  localparam int unsigned CNT_W     = $clog2(MEM_BYTES + 1),
  localparam int unsigned RC_W      = $clog2(NUM_REGS + 1)
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       valid_i,
  input  logic [1:0]                 elems_m1_i,
  input  logic [1:0]                 regs_m1_i,
  input  logic [1:0]                 esize_i,
  input  logic                       wide_i,
  input  logic                       alt_i,
  input  logic [RIDX_W-1:0]          first_reg_i,
  input  logic [MEM_BYTES*8-1:0]     mem_i,
  input  logic [MEM_BYTES*8-1:0]     reg_src_i,
  output logic                       valid_o,
  output logic                       illegal_o,
  output logic [CNT_W-1:0]           byte_count_o,
  output logic [NUM_REGS-1:0]        reg_en_o,
  output logic [NUM_REGS*RIDX_W-1:0] reg_num_o,
  output logic [MEM_BYTES*8-1:0]     reg_data_o,
  output logic [MEM_BYTES*8-1:0]     mem_o
);
  logic                       illegal_d;
  logic [RC_W-1:0]            reg_cnt;
  logic [CNT_W-1:0]           byte_cnt_d;
  logic [NUM_REGS-1:0]        reg_en_d;
  logic [NUM_REGS*RIDX_W-1:0] reg_num_d;
  logic [MEM_BYTES*8-1:0]     reg_data_d, mem_d;

  sil_ctrl #(.NUM_REGS(NUM_REGS), .REG_BYTES(REG_BYTES), .RIDX_W(RIDX_W)) u_ctrl (
    .elems_m1_i(elems_m1_i), .regs_m1_i(regs_m1_i), .esize_i(esize_i),
    .wide_i(wide_i), .alt_i(alt_i), .first_reg_i(first_reg_i),
    .illegal_o(illegal_d), .reg_cnt_o(reg_cnt), .byte_cnt_o(byte_cnt_d),
    .reg_en_o(reg_en_d), .reg_num_o(reg_num_d)
  );

  sil_load_xbar #(.NUM_REGS(NUM_REGS), .REG_BYTES(REG_BYTES)) u_load (
    .mem_i(mem_i), .elems_m1_i(elems_m1_i), .esize_i(esize_i), .wide_i(wide_i),
    .reg_cnt_i(reg_cnt), .reg_data_o(reg_data_d)
  );

  sil_store_xbar #(.NUM_REGS(NUM_REGS), .REG_BYTES(REG_BYTES)) u_store (
    .reg_src_i(reg_src_i), .elems_m1_i(elems_m1_i), .esize_i(esize_i), .wide_i(wide_i),
    .reg_cnt_i(reg_cnt), .mem_o(mem_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o      <= 1'b0;
      illegal_o    <= 1'b0;
      byte_count_o <= '0;
      reg_en_o     <= '0;
      reg_num_o    <= '0;
      reg_data_o   <= '0;
      mem_o        <= '0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) begin
        illegal_o    <= illegal_d;
        byte_count_o <= byte_cnt_d;
        reg_en_o     <= reg_en_d;
        reg_num_o    <= reg_num_d;
        reg_data_o   <= reg_data_d;
        mem_o        <= mem_d;
      end
    end
  end

  assert_first_reg_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> reg_num_o[RIDX_W-1:0] == $past(first_reg_i));
  assert_contig_en_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o && !illegal_o |-> reg_en_o[0] && $onehot({1'b0, reg_en_o} + {{NUM_REGS{1'b0}}, 1'b1}));
  assert_count_step_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o && !illegal_o |-> byte_count_o != '0 && byte_count_o[2:0] == 3'd0);
  assert_dword_narrow_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && !wide_i && esize_i == 2'd3 && elems_m1_i != 2'd0 |=> illegal_o);
  assert_alt_single_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && alt_i && elems_m1_i == 2'd0 |=> illegal_o);
  assert_quiet_illegal_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o && illegal_o |-> reg_en_o == '0 && byte_count_o == '0 && mem_o == '0 && reg_data_o == '0);
  assert_latency_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o);
  assert_hold_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> $stable(reg_data_o) && $stable(mem_o) && !valid_o);
endmodule

// File: tb/sil_top_bench.sv
module sil_top_bench;
  localparam int CLK_PERIOD = 10;

  logic clk = 0, rst_n = 0, valid = 0;
  logic [1:0] em1 = 0, rm1 = 0, esz = 0;
  logic wide = 0, alt = 0;
  logic [4:0] t = 0;
  logic [511:0] mem_in = '0, reg_in = '0;
  logic v_o, ill_o;
  logic [6:0] bc_o;
  logic [3:0] en_o;
  logic [19:0] num_o;
  logic [511:0] rd_o, mo_o;

  int checks = 0, errors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sil_top u_sil_top (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid), .elems_m1_i(em1), .regs_m1_i(rm1),
    .esize_i(esz), .wide_i(wide), .alt_i(alt), .first_reg_i(t), .mem_i(mem_in),
    .reg_src_i(reg_in), .valid_o(v_o), .illegal_o(ill_o), .byte_count_o(bc_o),
    .reg_en_o(en_o), .reg_num_o(num_o), .reg_data_o(rd_o), .mem_o(mo_o)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input logic [511:0] act, input logic [511:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // reference: scatter from memory element order, independent of gather form
  task automatic run_op(input logic [1:0] e, input logic [1:0] r, input logic [1:0] s,
                        input logic wd, input logic al, input logic [4:0] tt);
    int n, eb, w, cnt, nel;
    bit ill;
    logic [511:0] exp_rd, exp_mo;
    logic [3:0] exp_en;
    n = int'(e) + 1; eb = 1 << s; w = wd ? 16 : 8;
    ill = (al && n == 1) || (s == 2'd3 && !wd && n > 1);
    cnt = ill ? 0 : (n == 1 ? int'(r) + 1 : n);
    exp_rd = '0; exp_mo = '0; exp_en = '0;
    for (int k = 0; k < cnt; k++) exp_en[k] = 1'b1;
    if (!ill) begin
      if (n == 1) begin
        for (int b = 0; b < cnt*w; b++) begin
          exp_rd[((b/w)*16 + b%w)*8 +: 8] = mem_in[b*8 +: 8];
          exp_mo[b*8 +: 8] = reg_in[((b/w)*16 + b%w)*8 +: 8];
        end
      end else begin
        nel = cnt*w/eb;
        for (int i = 0; i < nel; i++)
          for (int q = 0; q < eb; q++) begin
            exp_rd[((i%n)*16 + (i/n)*eb + q)*8 +: 8] = mem_in[(i*eb+q)*8 +: 8];
            exp_mo[(i*eb+q)*8 +: 8] = reg_in[((i%n)*16 + (i/n)*eb + q)*8 +: 8];
          end
      end
    end
    @(negedge clk);
    em1 = e; rm1 = r; esz = s; wide = wd; alt = al; t = tt; valid = 1;
    @(negedge clk);
    valid = 0;
    check(v_o == 1'b1, "R11", "valid_o", 512'(v_o), 512'(1));
    check(ill_o == ill, ill && al ? "R8" : "R7", "illegal_o", 512'(ill_o), 512'(ill));
    check(bc_o == 7'(cnt*w), "R6", "byte_count_o", 512'(bc_o), 512'(cnt*w));
    check(en_o == exp_en, "R2", "reg_en_o", 512'(en_o), 512'(exp_en));
    for (int k = 0; k < cnt; k++)
      check(num_o[k*5 +: 5] == 5'((int'(tt) + (al ? 2*k : k)) % 32), "R1", "reg_num_o",
            512'(num_o[k*5 +: 5]), 512'((int'(tt) + (al ? 2*k : k)) % 32));
    check(rd_o == exp_rd, ill ? "R9" : (n == 1 ? "R3" : "R4"), "reg_data_o", rd_o, exp_rd);
    check(mo_o == exp_mo, ill ? "R9" : "R5", "mem_o", mo_o, exp_mo);
    // R10: zero tail is part of exp_rd/exp_mo; explicit spot check on top byte
    if (!ill && cnt*w < 64)
      check(mo_o[511 -: 8] == 8'h00, "R10", "mem_o tail", 512'(mo_o[511 -: 8]), 512'(0));
  endtask

  task automatic fill_random();
    for (int j = 0; j < 16; j++) begin
      mem_in[j*32 +: 32] = $urandom;
      reg_in[j*32 +: 32] = $urandom;
    end
  endtask

  initial begin
    logic [511:0] held;
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk);
    check(v_o == 0 && en_o == 0 && rd_o == 0 && mo_o == 0, "R11", "reset state",
          512'({v_o, en_o}), 512'(0));
    rst_n = 1;
    fill_random();
    run_op(2'd0, 2'd3, 2'd0, 1'b1, 1'b0, 5'd3);   // R3 four wide regs contiguous
    run_op(2'd0, 2'd1, 2'd3, 1'b0, 1'b0, 5'd31);  // R7 1D legal with n=1, wraps
    run_op(2'd1, 2'd0, 2'd3, 1'b0, 1'b0, 5'd0);   // R7 1D with n=2 illegal
    run_op(2'd0, 2'd0, 2'd0, 1'b1, 1'b1, 5'd4);   // R8 alt with n=1
    run_op(2'd3, 2'd0, 2'd1, 1'b1, 1'b1, 5'd30);  // R1 alt wrap 30,0,2,4
    run_op(2'd2, 2'd0, 2'd0, 1'b0, 1'b0, 5'd29);  // R4 three-byte structures narrow
    run_op(2'd2, 2'd0, 2'd2, 1'b1, 1'b1, 5'd7);   // R4 three-word structures
    run_op(2'd1, 2'd0, 2'd3, 1'b1, 1'b0, 5'd10);  // R4 2D pairs
    run_op(2'd0, 2'd0, 2'd1, 1'b0, 1'b0, 5'd1);   // R10 single narrow reg
    // R11 hold: change inputs without valid, outputs must stay
    held = rd_o;
    @(negedge clk); fill_random(); em1 = 2'd3;
    @(negedge clk);
    check(rd_o == held && v_o == 0, "R11", "hold without valid", rd_o, held);
    for (int it = 0; it < 300; it++) begin
      fill_random();
      run_op(2'($urandom), 2'($urandom), 2'($urandom), 1'($urandom),
             ($urandom % 4) == 0, 5'($urandom));
    end
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL R11 watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule